// File: doc/BRIEF.md
# Dual-Processor Mailbox FIFO

This block lets two processors exchange 32-bit words through a pair of one-way queues. Side 0 pushes into queue 0, which side 1 pops. Side 1 pushes into queue 1, which side 0 pops. Each side sees one 16-bit control/status word. That word shows the flags of the queue it sends into and of the queue it receives from. It also holds the side's global enable, its two interrupt enables, and a sticky error flag. Writing the word with the flush bit set empties the side's outgoing queue.

Each side has a 32-bit interrupt request vector. The block pulses a bit in it for one cycle when the side's outgoing queue is drained to empty by the peer. It pulses another bit when the side's incoming queue goes from empty to holding data. Only these transitions are reported, so a queue that stays empty or stays non-empty raises nothing further. The word returned by a pop appears on the reader's `pop_data` one cycle later. It stays there until the next successful pop.

Top module: `mbx_fifo_pair`

## Requirements
- R1: After reset both queues are empty. Each control word reads 16'h0011: send-empty at bit 0 and receive-empty at bit 4 are set, and every other bit is clear. `pop_data` and `irq_vec` are zero on both sides.
- R2: Each queue holds 16 words. A side's bit 0 (send empty) and bit 1 (send full) follow its own outgoing queue. Bit 4 (receive empty) and bit 5 (receive full) follow the peer's queue. Empty means an occupancy of 0 and full means an occupancy of 16, and the flags change in the cycle after the push or pop.
- R3: A push from a side whose enable bit 15 is clear is ignored. The queue, the flags and the error flag are left unchanged.
- R4: A push into a full queue is dropped, even when the peer pops in the same cycle. The drop sets the pusher's error flag.
- R5: Words leave a queue in the order they entered. The popped word appears on the reader's `pop_data` in the cycle after the pop and is held until the next successful pop.
- R6: A pop from an empty queue leaves the queue unchanged, keeps `pop_data` at the last word read (zero if none), and sets the reader's error flag.
- R7: The error flag at bit 14 is cleared by writing 1 and is left unchanged by writing 0. A write never sets it. An error event in the same cycle as a clearing write leaves it set.
- R8: A control write with bit 3 set empties the writer's outgoing queue. This sets send-empty on the writer and receive-empty on the peer and clears both full flags. It cancels any push or pop on that queue in the same cycle, raises no interrupt, and bit 3 reads 0.
- R9: When a queue goes from empty to non-empty and the reader's receive interrupt enable (bit 6) is set, bit 18 of the reader's `irq_vec` is high for exactly one cycle. This happens in the cycle the flags update.
- R10: When a pop drains a queue to empty and the sender's send interrupt enable (bit 2) is set, bit 17 of the sender's `irq_vec` is high for exactly one cycle. This happens in the cycle the flags update.
- R11: A successful push and pop on the same queue, neither empty nor full, in one cycle leave the occupancy unchanged and raise no interrupt. On an empty queue the pop fails as in R6 and the push lands, as in R9.
- R12: Only bits 2, 6 and 15 are stored by a control write. Writes to the flag bits are ignored. All `irq_vec` bits other than 17 and 18 read 0, including bit 16, which is kept for a separate sync interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 2 | Control write strobe, one bit per side |
| ctl_wdata | input | 2x16 | Control write data per side |
| ctl_rdata | output | 2x16 | Control/status word per side |
| push_valid | input | 2 | Push into the side's outgoing queue |
| push_data | input | 2x32 | Word pushed by each side |
| pop_req | input | 2 | Pop from the side's incoming queue |
| pop_data | output | 2x32 | Last word popped by each side |
| irq_vec | output | 2x32 | Interrupt request pulses per side (bit 17 send empty, bit 18 receive not empty) |

## Verification
Short directed bursts separate FIFO ordering from flag timing. A single word, three words and a full sixteen-plus-one fill each show whether occupancy, the full flag and the drop on overflow agree. Paired push-and-pop cycles on a half-filled queue and on an empty queue tell a true transition interrupt from a spurious one. A flush with a pop in the same cycle shows which of the two wins. A long run of random pushes, pops and occasional control writes on both sides at once, compared every cycle against a queue-based model, checks that the two directions never disturb each other.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned CTL_W         = 16;
   localparam int unsigned IRQ_W         = 32;

   localparam int unsigned CB_SEND_EMPTY = 0;
   localparam int unsigned CB_SEND_FULL  = 1;
   localparam int unsigned CB_SEND_IE    = 2;
   localparam int unsigned CB_FLUSH      = 3;
   localparam int unsigned CB_RECV_EMPTY = 4;
   localparam int unsigned CB_RECV_FULL  = 5;
   localparam int unsigned CB_RECV_IE    = 6;
   localparam int unsigned CB_ERR        = 14;
   localparam int unsigned CB_EN         = 15;

   localparam int unsigned IB_SEND_EMPTY = 17;
   localparam int unsigned IB_RECV_NE    = 18;

   typedef struct packed {
      logic en;
      logic send_ie;
      logic recv_ie;
   } side_cfg_t;
endpackage

// File: rtl/mbx_queue.sv
module mbx_queue #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_en,
   input  logic              pop_en,
   input  logic              flush,
   input  logic [DATA_W-1:0] push_data,
   output logic [DATA_W-1:0] head_data,
   output logic [CW-1:0]     count
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     rd_ptr;

   always_ff @(posedge clk) begin
      if (push_en && !flush) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_en) wr_ptr <= wr_ptr + 1'b1;
         if (pop_en)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_en, pop_en})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head_data = mem[rd_ptr];

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   p_push_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push_en && !pop_en && !flush |=> count == CW'($past(count) + 1'b1));
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      count == CW'(DEPTH) |-> !push_en);
   p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      count == '0 |-> !pop_en);
   p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> count == '0);
endmodule

// File: rtl/mbx_side_regs.sv
module mbx_side_regs
   import mbx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             err_set,
   output side_cfg_t        cfg,
   output logic             err,
   output logic             flush_cmd
);
   logic err_clr;
   logic unused_bits;

   assign flush_cmd   = ctl_we && ctl_wdata[CB_FLUSH];
   assign err_clr     = ctl_we && ctl_wdata[CB_ERR];
   assign unused_bits = ^ctl_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (ctl_we) begin
         cfg.en      <= ctl_wdata[CB_EN];
         cfg.send_ie <= ctl_wdata[CB_SEND_IE];
         cfg.recv_ie <= ctl_wdata[CB_RECV_IE];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err <= 1'b0;
      else if (err_set) err <= 1'b1;
      else if (err_clr) err <= 1'b0;
   end

   p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr && !err_set |=> !err);
   p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err && !err_clr |=> err);
   p_err_no_write_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !err && !err_set |=> !err);
endmodule

// File: rtl/mbx_irq_edge.sv
module mbx_irq_edge #(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_en,
   input  logic          pop_en,
   input  logic [CW-1:0] count,
   input  logic          send_ie,
   input  logic          recv_ie,
   output logic          send_pulse,
   output logic          recv_pulse
);
   logic drain_now;
   logic fill_now;

   assign drain_now = pop_en && !push_en && (count == CW'(1));
   assign fill_now  = push_en && (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         send_pulse <= 1'b0;
         recv_pulse <= 1'b0;
      end else begin
         send_pulse <= send_ie && drain_now;
         recv_pulse <= recv_ie && fill_now;
      end
   end

   p_send_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      send_pulse |=> !send_pulse);
   p_recv_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      recv_pulse |=> !recv_pulse);
   p_send_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_en |=> !send_pulse);
   p_recv_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !push_en |=> !recv_pulse);
endmodule

// File: rtl/mbx_fifo_pair.sv
module mbx_fifo_pair
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  ctl_we,
   input  logic [1:0][CTL_W-1:0]       ctl_wdata,
   output logic [1:0][CTL_W-1:0]       ctl_rdata,
   input  logic [1:0]                  push_valid,
   input  logic [1:0][DATA_W-1:0]      push_data,
   input  logic [1:0]                  pop_req,
   output logic [1:0][DATA_W-1:0]      pop_data,
   output logic [1:0][IRQ_W-1:0]       irq_vec
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("mbx_fifo_pair: DEPTH must be a power of two of at least 2");
   end
   if (DATA_W == 0) begin : g_bad_width
      $error("mbx_fifo_pair: DATA_W must be non-zero");
   end
   if (IB_RECV_NE >= IRQ_W || CB_EN >= CTL_W) begin : g_bad_map
      $error("mbx_fifo_pair: bit map exceeds register width");
   end

   side_cfg_t         cfg   [2];
   logic [CW-1:0]     cnt   [2];
   logic [DATA_W-1:0] head  [2];
   logic [1:0]        err;
   logic [1:0]        err_set;
   logic [1:0]        flush;
   logic [1:0]        push_en;
   logic [1:0]        pop_en;
   logic [1:0]        push_err;
   logic [1:0]        pop_err;
   logic [1:0]        send_pulse;
   logic [1:0]        recv_pulse;
   logic [1:0]        q_full;
   logic [1:0]        q_empty;

   for (genvar s = 0; s < 2; s++) begin : g_side
      localparam int unsigned P = 1 - s;

      logic [CTL_W-1:0]  rd_word;
      logic [IRQ_W-1:0]  irq_word;
      logic [DATA_W-1:0] last_rd;

      assign q_full[s]   = (cnt[s] == CW'(DEPTH));
      assign q_empty[s]  = (cnt[s] == '0);
      assign push_en[s]  = push_valid[s] && cfg[s].en && !q_full[s] && !flush[s];
      assign push_err[s] = push_valid[s] && cfg[s].en &&  q_full[s] && !flush[s];
      assign pop_en[s]   = pop_req[P] && !q_empty[s] && !flush[s];
      assign pop_err[s]  = pop_req[P] &&  q_empty[s] && !flush[s];
      assign err_set[s]  = push_err[s] || pop_err[P];

      mbx_side_regs i_regs (
         .clk       (clk),
         .rst_n     (rst_n),
         .ctl_we    (ctl_we[s]),
         .ctl_wdata (ctl_wdata[s]),
         .err_set   (err_set[s]),
         .cfg       (cfg[s]),
         .err       (err[s]),
         .flush_cmd (flush[s])
      );

      mbx_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_queue (
         .clk       (clk),
         .rst_n     (rst_n),
         .push_en   (push_en[s]),
         .pop_en    (pop_en[s]),
         .flush     (flush[s]),
         .push_data (push_data[s]),
         .head_data (head[s]),
         .count     (cnt[s])
      );

      mbx_irq_edge #(.CW(CW)) i_edge (
         .clk        (clk),
         .rst_n      (rst_n),
         .push_en    (push_en[s]),
         .pop_en     (pop_en[s]),
         .count      (cnt[s]),
         .send_ie    (cfg[s].send_ie),
         .recv_ie    (cfg[P].recv_ie),
         .send_pulse (send_pulse[s]),
         .recv_pulse (recv_pulse[s])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        last_rd <= '0;
         else if (pop_en[P]) last_rd <= head[P];
      end

      always_comb begin
         rd_word                = '0;
         rd_word[CB_SEND_EMPTY] = q_empty[s];
         rd_word[CB_SEND_FULL]  = q_full[s];
         rd_word[CB_SEND_IE]    = cfg[s].send_ie;
         rd_word[CB_RECV_EMPTY] = q_empty[P];
         rd_word[CB_RECV_FULL]  = q_full[P];
         rd_word[CB_RECV_IE]    = cfg[s].recv_ie;
         rd_word[CB_ERR]        = err[s];
         rd_word[CB_EN]         = cfg[s].en;
      end

      always_comb begin
         irq_word                = '0;
         irq_word[IB_SEND_EMPTY] = send_pulse[s];
         irq_word[IB_RECV_NE]    = recv_pulse[P];
      end

      assign ctl_rdata[s] = rd_word;
      assign pop_data[s]  = last_rd;
      assign irq_vec[s]   = irq_word;

      p_send_irq_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
         irq_vec[s][IB_SEND_EMPTY] |-> ctl_rdata[s][CB_SEND_EMPTY]);
      p_recv_irq_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
         irq_vec[s][IB_RECV_NE] |-> !ctl_rdata[s][CB_RECV_EMPTY]);
      p_disabled_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
         push_valid[s] && !ctl_rdata[s][CB_EN] && !pop_req[P] && !ctl_we[s]
         |=> cnt[s] == $past(cnt[s]));
      p_empty_pop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
         pop_req[s] && ctl_rdata[s][CB_RECV_EMPTY] |=> $stable(pop_data[s]));
      p_flush_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
         ctl_we[s] && ctl_wdata[s][CB_FLUSH] |=> !irq_vec[s][IB_SEND_EMPTY]);
      p_spare_irq_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(irq_vec[s]) == $countones(irq_vec[s][IB_RECV_NE:IB_SEND_EMPTY]));
   end
endmodule

// File: tb/test_mbx_fifo_pair.sv
`timescale 1ns/1ps
module test_mbx_fifo_pair;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        ctl_we = '0;
   logic [1:0][15:0]  ctl_wdata = '0;
   logic [1:0][15:0]  ctl_rdata;
   logic [1:0]        push_valid = '0;
   logic [1:0][31:0]  push_data = '0;
   logic [1:0]        pop_req = '0;
   logic [1:0][31:0]  pop_data;
   logic [1:0][31:0]  irq_vec;

   int    checks = 0;
   int    errors = 0;
   string phase  = "R1";
   bit    run_cmp = 1'b0;

   always #2.5 clk = ~clk;

   mbx_fifo_pair i_mbx_fifo_pair (
      .clk(clk), .rst_n(rst_n),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .push_valid(push_valid), .push_data(push_data),
      .pop_req(pop_req), .pop_data(pop_data), .irq_vec(irq_vec)
   );

   // Reference model: two word queues and per-side registers
   logic [31:0] mq [2][$];
   bit          m_en [2], m_sie [2], m_rie [2], m_err [2];
   bit          m_irqs [2], m_irqr [2];
   logic [31:0] m_last [2];

   always @(posedge clk or negedge rst_n) begin : model
      bit          eset [2];
      bit          nirqs [2], nirqr [2];
      int          old, r;
      logic [31:0] w;
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin
            mq[i].delete();
            m_en[i] = 0; m_sie[i] = 0; m_rie[i] = 0; m_err[i] = 0;
            m_irqs[i] = 0; m_irqr[i] = 0; m_last[i] = '0;
         end
      end else begin
         for (int i = 0; i < 2; i++) begin
            eset[i] = 0; nirqs[i] = 0; nirqr[i] = 0;
         end
         for (int q = 0; q < 2; q++) begin
            r   = 1 - q;
            old = mq[q].size();
            if (ctl_we[q] && ctl_wdata[q][3]) begin
               mq[q].delete();
            end else begin
               if (pop_req[r]) begin
                  if (old > 0) begin
                     w = mq[q].pop_front();
                     m_last[r] = w;
                  end else eset[r] = 1;
               end
               if (push_valid[q] && m_en[q]) begin
                  if (old < 16) mq[q].push_back(push_data[q]);
                  else eset[q] = 1;
               end
               nirqs[q] = m_sie[q] && old != 0 && mq[q].size() == 0;
               nirqr[r] = m_rie[r] && old == 0 && mq[q].size() != 0;
            end
         end
         for (int s = 0; s < 2; s++) begin
            if (ctl_we[s]) begin
               m_en[s]  = ctl_wdata[s][15];
               m_sie[s] = ctl_wdata[s][2];
               m_rie[s] = ctl_wdata[s][6];
            end
            if (eset[s]) m_err[s] = 1;
            else if (ctl_we[s] && ctl_wdata[s][14]) m_err[s] = 0;
            m_irqs[s] = nirqs[s];
            m_irqr[s] = nirqr[s];
         end
      end
   end

   task automatic check(string rq, int s, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s side %0d phase %s: got %h expected %h", rq, s, phase, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && run_cmp) begin
         for (int s = 0; s < 2; s++) begin
            automatic int p = 1 - s;
            automatic logic [15:0] wv = ctl_rdata[s];
            automatic logic [31:0] iv = irq_vec[s];
            check("R2", s, {30'd0, wv[1], wv[0]},
                  {30'd0, mq[s].size() == 16, mq[s].size() == 0});
            check("R2", s, {30'd0, wv[5], wv[4]},
                  {30'd0, mq[p].size() == 16, mq[p].size() == 0});
            check("R12", s, {29'd0, wv[15], wv[6], wv[2]},
                  {29'd0, m_en[s], m_rie[s], m_sie[s]});
            check("R12", s, {16'd0, wv[13:7], wv[3]}, '0);
            check("R7", s, {31'd0, wv[14]}, {31'd0, m_err[s]});
            check("R5", s, pop_data[s], m_last[s]);
            check("R10", s, {31'd0, iv[17]}, {31'd0, m_irqs[s]});
            check("R9", s, {31'd0, iv[18]}, {31'd0, m_irqr[s]});
            check("R12", s, iv & ~32'h0006_0000, '0);
         end
      end
   end

   task automatic clear_in();
      ctl_we = '0; push_valid = '0; pop_req = '0;
   endtask

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
      clear_in();
   endtask

   task automatic wr_ctl(int s, logic [15:0] v);
      ctl_we[s] = 1'b1; ctl_wdata[s] = v; tick();
   endtask

   task automatic push(int s, logic [31:0] d);
      push_valid[s] = 1'b1; push_data[s] = d; tick();
   endtask

   task automatic pop(int s);
      pop_req[s] = 1'b1; tick();
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog: run still active, expected end before 150000 cycles");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state seen at the ports
      for (int s = 0; s < 2; s++) begin
         check("R1", s, {16'd0, ctl_rdata[s]}, 32'h0000_0011);
         check("R1", s, pop_data[s], '0);
         check("R1", s, irq_vec[s], '0);
      end
      run_cmp = 1'b1;

      phase = "R3";
      push(0, 32'hDEAD_0001);
      tick(2);

      phase = "R12";
      wr_ctl(0, 16'h8044 | 16'h0033);
      wr_ctl(1, 16'h8044 | 16'h0033);
      tick();

      phase = "R2";
      push(0, 32'h1111_0001);
      push(0, 32'h1111_0002);
      push(0, 32'h1111_0003);
      tick(2);

      phase = "R5";
      pop(1); pop(1); pop(1);
      tick(2);

      phase = "R6";
      pop(1);
      tick(2);
      phase = "R7";
      wr_ctl(1, 16'h8044);
      tick();
      wr_ctl(1, 16'hC044);
      tick();
      // clear and error in the same cycle: error stays set
      ctl_we[0] = 1'b1; ctl_wdata[0] = 16'hC044; pop_req[0] = 1'b1; tick();
      tick();
      wr_ctl(0, 16'hC044);

      phase = "R4";
      for (int i = 0; i < 17; i++) push(1, 32'h2000_0000 + i);
      tick();
      push_valid[1] = 1'b1; push_data[1] = 32'h2FFF_FFFF; pop_req[0] = 1'b1; tick();
      tick();
      wr_ctl(1, 16'hC044);

      phase = "R11";
      push_valid[1] = 1'b1; push_data[1] = 32'h3000_0001; pop_req[0] = 1'b1; tick();
      push_valid[1] = 1'b1; push_data[1] = 32'h3000_0002; pop_req[0] = 1'b1; tick();
      tick();
      push_valid[0] = 1'b1; push_data[0] = 32'h3100_0001; pop_req[1] = 1'b1; tick();
      tick();
      wr_ctl(1, 16'hC044);

      phase = "R8";
      ctl_we[1] = 1'b1; ctl_wdata[1] = 16'h804C; pop_req[0] = 1'b1; tick();
      tick();
      ctl_we[0] = 1'b1; ctl_wdata[0] = 16'h804C; push_valid[0] = 1'b1;
      push_data[0] = 32'h4000_0001; tick();
      tick(2);

      phase = "R9";
      wr_ctl(0, 16'h8000);
      wr_ctl(1, 16'h8000);
      push(0, 32'h5000_0001);
      pop(1);
      tick(2);
      wr_ctl(0, 16'h8044);
      wr_ctl(1, 16'h8044);
      push(1, 32'h5100_0001);
      tick();
      phase = "R10";
      pop(0);
      tick(2);

      phase = "mix";
      for (int c = 0; c < 4000; c++) begin
         for (int s = 0; s < 2; s++) begin
            push_valid[s] = ($urandom_range(0, 99) < 55);
            push_data[s]  = $urandom();
            pop_req[s]    = ($urandom_range(0, 99) < 45);
            if ($urandom_range(0, 99) < 3) begin
               ctl_we[s]    = 1'b1;
               ctl_wdata[s] = 16'($urandom()) | 16'h8000;
               if ($urandom_range(0, 3) != 0) ctl_wdata[s][3] = 1'b0;
            end
         end
         tick();
      end
      tick(3);
      finish_run();
   end
endmodule